// File: doc/BRIEF.md
# Gray-Pointer Elastic Circular Buffer

This block is a 128-word circular buffer that sits between an input clock domain and an output processing clock domain. It absorbs short-term rate jitter between the two clocks, which an external loop keeps frequency-locked. The buffer has no full or empty flow control. A host command places the read position at a programmed distance from the write position, and from then on both positions advance on their own. The write side advances once per valid input word. The read side advances once every four output-clock cycles in 4x oversampling mode, or once every two in 2x mode.

Both positions are held as Gray-code counters. The write position crosses into the read domain through a two-stage synchronizer and is compared there with the read position. An equality is a collision. It drives a registered alarm output, a one-cycle interrupt event and a sticky status bit that the host clears by reading it. The distance must be written as a Gray number with an even count of ones. A load that breaks this rule changes nothing in the buffer and sets a configuration-error bit instead.

Top module: `elastic_gray_ring`

## Requirements
- R1: After reset, every output is low and the read side stays idle. It makes no reads and raises no alarm until the first accepted position load.
- R2: A load whose Gray value `loadGray` has an even number of ones is accepted on the read-clock edge where `loadReq` is high. The read position becomes that value. The write position is forced to zero on the third write-clock edge after the command, and any word offered on that edge is discarded.
- R3: Once running, `rdValid` pulses for one cycle every 4 read-clock cycles when `overSel` is 1, and every 2 cycles when it is 0. The divider restarts at an accepted load, so the first read comes on the 4th (or 2nd) edge after the load edge.
- R4: A word on `wrData` is stored, and the write position advances, only on a write-clock edge with `wrValid` high. Each read returns the word stored at the read position and then moves to the next position, wrapping after 127.
- R5: A load whose value has an odd number of ones leaves the read position, the divider and the write position unchanged, and sets `cfgErr` on the next edge.
- R6: While running, `alarm` is high in the cycle after an edge where the read position equals the write position as seen through the two-stage synchronizer. Operation continues without any blocking.
- R7: `alarmSticky` is set together with every alarm and holds until a `statusRead` cycle that has no new collision. A collision wins over a clear in the same cycle.
- R8: `alarmEvent` is a one-cycle pulse in the first cycle of each alarm run.
- R9: `cfgErr` holds until `statusRead` is high in a cycle with no new odd-parity load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Input-domain clock |
| wrRstN | input | 1 | Asynchronous active-low reset, input domain |
| wrData | input | 8 | Input word |
| wrValid | input | 1 | Input word valid; the write side advances only when high |
| rdClk | input | 1 | Output processing clock |
| rdRstN | input | 1 | Asynchronous active-low reset, output domain |
| overSel | input | 1 | 1: read every 4 cycles; 0: read every 2 cycles |
| loadReq | input | 1 | One-cycle command to load the read position |
| loadGray | input | 7 | Gray-coded read position for the load; must have even parity |
| statusRead | input | 1 | Host read of status; clears the sticky bits |
| rdData | output | 8 | Word read from the buffer |
| rdValid | output | 1 | One-cycle pulse when `rdData` is updated |
| alarm | output | 1 | Registered collision indication |
| alarmSticky | output | 1 | Sticky collision status |
| alarmEvent | output | 1 | One-cycle interrupt event at the start of a collision |
| cfgErr | output | 1 | Sticky flag for a rejected odd-parity load |

## Verification
The hardest state to reach from the ports is an actual pointer collision. It arises only when the writer runs faster than the reader for long enough to close the programmed gap, or when the reader laps a stalled writer. The stimulus creates both cases. In one phase words arrive every cycle while reads happen every fourth cycle, so the write position overtakes the read position several times. In another phase writes stop entirely and the reader wraps onto the frozen write position. The reference model tracks the synchronizer lag and the delayed write clear, so the exact cycle of each alarm, event and sticky update is predicted and compared.

// File: rtl/egr_pkg.sv
package egr_pkg;
  // strobes from the control unit to the datapath (read domain)
  typedef struct packed {
    logic loadPtr;   // accept the loaded Gray position
    logic readTick;  // perform one read and advance
  } ctlStrobe_t;
endpackage

// File: rtl/egr_sync.sv
module egr_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[0] <= '0;
        else       stage[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[s] <= '0;
        else       stage[s] <= stage[s-1];
      end
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/egr_datapath.sv
module egr_datapath
  import egr_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wrClk,
  input  logic              wrRstN,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrValid,
  input  logic              rdClk,
  input  logic              rdRstN,
  input  ctlStrobe_t        strobe,
  input  logic [ADDR_W-1:0] loadGray,
  output logic [DATA_W-1:0] rdData,
  output logic              ptrsEqual
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  function automatic logic [ADDR_W-1:0] gray2bin(input logic [ADDR_W-1:0] g);
    logic [ADDR_W-1:0] b;
    b[ADDR_W-1] = g[ADDR_W-1];
    for (int i = ADDR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [ADDR_W-1:0] grayInc(input logic [ADDR_W-1:0] g);
    logic [ADDR_W-1:0] b;
    b = gray2bin(g) + ONE;
    return b ^ (b >> 1);
  endfunction

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] rdPtrG, wrPtrG, wrPtrSync;
  logic [DATA_W-1:0] rdDataQ;
  logic              loadTgl, loadTglSync, loadTglPrev, wrClear;
  logic              loadPtr;

  assign loadPtr = strobe.loadPtr;

  // read domain: position register and output word
  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      rdPtrG  <= '0;
      loadTgl <= 1'b0;
      rdDataQ <= '0;
    end else if (strobe.loadPtr) begin
      rdPtrG  <= loadGray;
      loadTgl <= ~loadTgl;
    end else if (strobe.readTick) begin
      rdDataQ <= mem[gray2bin(rdPtrG)];
      rdPtrG  <= grayInc(rdPtrG);
    end
  end

  // load command crosses into the write domain as a toggle
  egr_sync #(.W(1), .STAGES(SYNC_STAGES)) i_loadSync (
    .clk(wrClk), .rstN(wrRstN), .d(loadTgl), .q(loadTglSync)
  );

  assign wrClear = loadTglSync ^ loadTglPrev;

  // write domain: storage and Gray write position
  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      wrPtrG      <= '0;
      loadTglPrev <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      loadTglPrev <= loadTglSync;
      if (wrClear) begin
        wrPtrG <= '0;
      end else if (wrValid) begin
        mem[gray2bin(wrPtrG)] <= wrData;
        wrPtrG <= grayInc(wrPtrG);
      end
    end
  end

  // write position seen from the read domain
  egr_sync #(.W(ADDR_W), .STAGES(SYNC_STAGES)) i_ptrSync (
    .clk(rdClk), .rstN(rdRstN), .d(wrPtrG), .q(wrPtrSync)
  );

  assign ptrsEqual = (rdPtrG == wrPtrSync);
  assign rdData    = rdDataQ;

  // R4
  wr_gray_step_chk: assert property (@(posedge wrClk) disable iff (!wrRstN)
    !$past(wrClear) |-> ($countones(wrPtrG ^ $past(wrPtrG)) <= 1));

  // R4
  wr_hold_chk: assert property (@(posedge wrClk) disable iff (!wrRstN)
    (!$past(wrValid) && !$past(wrClear)) |-> $stable(wrPtrG));

  // R2
  rd_load_chk: assert property (@(posedge rdClk) disable iff (!rdRstN)
    $past(loadPtr) |-> (rdPtrG == $past(loadGray)));

  // R3
  rd_gray_step_chk: assert property (@(posedge rdClk) disable iff (!rdRstN)
    !$past(loadPtr) |-> ($countones(rdPtrG ^ $past(rdPtrG)) <= 1));
endmodule

// File: rtl/egr_ctrl.sv
module egr_ctrl
  import egr_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              rdClk,
  input  logic              rdRstN,
  input  logic              overSel,
  input  logic              loadReq,
  input  logic [ADDR_W-1:0] loadGray,
  input  logic              statusRead,
  input  logic              ptrsEqual,
  output ctlStrobe_t        strobe,
  output logic              rdValid,
  output logic              alarm,
  output logic              alarmSticky,
  output logic              alarmEvent,
  output logic              cfgErr
);
  localparam int DIV_W = 2;

  logic [DIV_W-1:0] divCnt, divLast;
  logic             running, parityOk, goodLoad, badLoad, tickNow, hit;

  assign parityOk = ~^loadGray;
  assign goodLoad = loadReq & parityOk;
  assign badLoad  = loadReq & ~parityOk;
  assign divLast  = overSel ? DIV_W'(3) : DIV_W'(1);
  assign tickNow  = running & ~goodLoad & (divCnt >= divLast);
  assign hit      = running & ptrsEqual;

  assign strobe.loadPtr  = goodLoad;
  assign strobe.readTick = tickNow;

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      running     <= 1'b0;
      divCnt      <= '0;
      rdValid     <= 1'b0;
      alarm       <= 1'b0;
      alarmEvent  <= 1'b0;
      alarmSticky <= 1'b0;
      cfgErr      <= 1'b0;
    end else begin
      running <= running | goodLoad;
      if (goodLoad)     divCnt <= '0;
      else if (running) divCnt <= tickNow ? '0 : divCnt + DIV_W'(1);
      rdValid     <= tickNow;
      alarm       <= hit;
      alarmEvent  <= hit & ~alarm;
      alarmSticky <= hit | (alarmSticky & ~statusRead);
      cfgErr      <= badLoad | (cfgErr & ~statusRead);
    end
  end

  // R5
  cfg_err_cause_chk: assert property (@(posedge rdClk) disable iff (!rdRstN)
    $rose(cfgErr) |-> ($past(loadReq) && $past(^loadGray)));

  // R7
  sticky_follow_chk: assert property (@(posedge rdClk) disable iff (!rdRstN)
    alarm |-> alarmSticky);

  // R8
  event_edge_chk: assert property (@(posedge rdClk) disable iff (!rdRstN)
    alarmEvent |-> (alarm && !$past(alarm)));

  // R3
  tick_spacing_chk: assert property (@(posedge rdClk) disable iff (!rdRstN)
    rdValid |=> !rdValid);
endmodule

// File: rtl/elastic_gray_ring.sv
module elastic_gray_ring
  import egr_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wrClk,
  input  logic              wrRstN,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrValid,
  input  logic              rdClk,
  input  logic              rdRstN,
  input  logic              overSel,
  input  logic              loadReq,
  input  logic [ADDR_W-1:0] loadGray,
  input  logic              statusRead,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              alarm,
  output logic              alarmSticky,
  output logic              alarmEvent,
  output logic              cfgErr
);
  ctlStrobe_t strobe;
  logic       ptrsEqual;

  egr_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .rdClk(rdClk), .rdRstN(rdRstN), .overSel(overSel), .loadReq(loadReq),
    .loadGray(loadGray), .statusRead(statusRead), .ptrsEqual(ptrsEqual),
    .strobe(strobe), .rdValid(rdValid), .alarm(alarm),
    .alarmSticky(alarmSticky), .alarmEvent(alarmEvent), .cfgErr(cfgErr)
  );

  egr_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) i_dp (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrData(wrData), .wrValid(wrValid),
    .rdClk(rdClk), .rdRstN(rdRstN), .strobe(strobe), .loadGray(loadGray),
    .rdData(rdData), .ptrsEqual(ptrsEqual)
  );
endmodule

// File: tb/test_elastic_gray_ring.sv
module test_elastic_gray_ring;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] wrData = '0;
  logic       wrValid = 1'b0;
  logic       overSel = 1'b1;
  logic       loadReq = 1'b0;
  logic [6:0] loadGray = '0;
  logic       statusRead = 1'b0;
  logic [7:0] rdData;
  logic       rdValid, alarm, alarmSticky, alarmEvent, cfgErr;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int wrMode = 0;
  bit chkOn  = 1'b0;

  always #4 clk = ~clk;  // 125 MHz, both domains frequency-locked

  elastic_gray_ring i_elastic_gray_ring (
    .wrClk(clk), .wrRstN(rstN), .wrData(wrData), .wrValid(wrValid),
    .rdClk(clk), .rdRstN(rstN), .overSel(overSel), .loadReq(loadReq),
    .loadGray(loadGray), .statusRead(statusRead), .rdData(rdData),
    .rdValid(rdValid), .alarm(alarm), .alarmSticky(alarmSticky),
    .alarmEvent(alarmEvent), .cfgErr(cfgErr)
  );

  // ---------------- behavioural reference model ----------------
  int mMem [128];
  int mRd, mWr, mWrD1, mWrD2, mDiv, mClr, mData;
  bit mRun, mVld, mAlm, mEvt, mSticky, mCfg;

  function automatic int grayToInt(input logic [6:0] g);
    int v = 0;
    bit acc = 0;
    for (int i = 6; i >= 0; i--) begin
      acc = acc ^ g[i];
      v = v * 2 + int'(acc);
    end
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      foreach (mMem[i]) mMem[i] = 0;
      mRd = 0; mWr = 0; mWrD1 = 0; mWrD2 = 0; mDiv = 0; mClr = 0; mData = 0;
      mRun = 0; mVld = 0; mAlm = 0; mEvt = 0; mSticky = 0; mCfg = 0;
    end else begin
      bit eqPrev, goodL, badL, tick, doClr;
      int lastDiv;
      eqPrev  = mRun && (mRd == mWrD2);
      goodL   = loadReq && !(^loadGray);
      badL    = loadReq && (^loadGray);
      lastDiv = overSel ? 3 : 1;
      tick    = mRun && !goodL && (mDiv >= lastDiv);
      mVld    = tick;
      if (tick) begin
        mData = mMem[mRd];
        mRd   = (mRd + 1) % 128;
      end
      if (goodL) begin
        mRd = grayToInt(loadGray); mDiv = 0; mRun = 1;
      end else if (mRun) begin
        mDiv = tick ? 0 : mDiv + 1;
      end
      mEvt    = eqPrev && !mAlm;
      mAlm    = eqPrev;
      mSticky = eqPrev || (mSticky && !statusRead);
      mCfg    = badL || (mCfg && !statusRead);
      doClr = (mClr == 1);
      if (mClr > 0) mClr--;
      mWrD2 = mWrD1;
      mWrD1 = mWr;
      if (doClr) mWr = 0;
      else if (wrValid) begin
        mMem[mWr] = int'(wrData);
        mWr = (mWr + 1) % 128;
      end
      if (goodL) mClr = 3;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (chkOn) begin
      chk("R3 rdValid", 16'(rdValid), 16'(mVld));
      chk("R2 R4 rdData", 16'(rdData), 16'(mData));
      chk("R6 alarm", 16'(alarm), 16'(mAlm));
      chk("R7 alarmSticky", 16'(alarmSticky), 16'(mSticky));
      chk("R8 alarmEvent", 16'(alarmEvent), 16'(mEvt));
      chk("R5 R9 cfgErr", 16'(cfgErr), 16'(mCfg));
    end
  end

  // ---------------- stimulus ----------------
  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cyc++;
      loadReq    = 1'b0;
      statusRead = 1'b0;
      wrValid    = (wrMode != 0) && (cyc % wrMode == 0);
      wrData     = 8'(cyc * 37 + 11);
    end
  endtask

  task automatic doLoad(input logic [6:0] g);
    @(negedge clk);
    cyc++;
    loadReq    = 1'b1;
    loadGray   = g;
    statusRead = 1'b0;
    wrValid    = 1'b0;
  endtask

  task automatic doStatus();
    @(negedge clk);
    cyc++;
    loadReq    = 1'b0;
    statusRead = 1'b1;
    wrValid    = 1'b0;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    run(4);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: idle state straight after reset
    chk("R1 rdValid", 16'(rdValid), 16'd0);
    chk("R1 rdData", 16'(rdData), 16'd0);
    chk("R1 alarm", 16'(alarm), 16'd0);
    chk("R1 alarmSticky", 16'(alarmSticky), 16'd0);
    chk("R1 alarmEvent", 16'(alarmEvent), 16'd0);
    chk("R1 cfgErr", 16'(cfgErr), 16'd0);
    chkOn = 1'b1;
    // R1/R4: fill while not running; no reads, no alarm
    wrMode = 1; run(50);
    // R2/R3: even-parity load (Gray 0x60 -> position 64), matched rates in 4x
    wrMode = 4; doLoad(7'h60); run(300);
    // R5/R9: odd-parity load rejected, then cleared by a status read
    doLoad(7'h01); run(20); doStatus(); run(10);
    // R6/R7/R8: writer overtakes reader repeatedly, status read in between
    wrMode = 1; run(250); doStatus(); run(100); doStatus(); run(60);
    // R3: 2x mode, Gray 0x05 -> position 6
    overSel = 1'b0; wrMode = 2; doLoad(7'h05); run(200);
    // R4/R6: writer stalled, reader from position 0 laps onto it
    overSel = 1'b1; wrMode = 0; doLoad(7'h00); run(600); doStatus(); run(30);
    // R3: mode switch while running
    overSel = 1'b0; wrMode = 3; run(40); overSel = 1'b1; run(40);
    finishRun();
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    finishRun();
  end
endmodule